// File: doc/BRIEF.md
# Serial Controller Control-Write Format Sequencer

This block sits behind the CPU port of a small synchronous/asynchronous serial controller. Every byte the CPU writes to the control address carries a meaning that depends on a hidden format state. After a reset the first control byte is a mode word. In synchronous operation the next one or two control bytes are sync characters. Every later control byte is a command word, until a command asks for an internal reset and the sequence starts over. Bytes written to the data address pass by and do not touch this state.

The block holds the mode word, the sync characters and the command register. It drives the active-low terminal-ready and request-to-send lines. It hands enable levels, a break request, a one-cycle error-flag clear pulse and a one-cycle hunt start pulse to the transmit and receive engines. Driver code can always reach a known state without knowing the current one: it writes three 00h bytes to the control address, and the block is then waiting for a command word.

Top module: `usart_ctl_seq`

## Requirements
- R1: While `usart_reset` is high at a clock edge, the command register clears: `tx_en`, `rx_en` and `send_break` are 0, and `dtr_n` and `rts_n` are 1. The first control write after reset is stored as the mode word on `mode_word`.
- R2: Mode word bits [1:0] = 00 select synchronous operation (`sync_mode` = 1). The values 01, 10 and 11 select asynchronous operation at clock factor 1x, 16x and 64x (`sync_mode` = 0).
- R3: In synchronous operation, mode bit 7 = 0 means two sync characters follow the mode word and bit 7 = 1 means one. Sync character k appears on `sync_chars[8k+7:8k]`. The control write after the last sync character is the first command word.
- R4: In asynchronous operation, the control write right after the mode word is a command word.
- R5: Three consecutive 00h control writes, started in any format state, leave the block taking the next control write as a command word.
- R6: A command word with bit 6 set clears the command register. The next control write is then taken as a mode word.
- R7: In a command word, bit 0 drives `tx_en`, bit 2 drives `rx_en` and bit 3 drives `send_break`. These levels hold until the next command word.
- R8: `dtr_n` is the inverse of command bit 1 and `rts_n` is the inverse of command bit 5.
- R9: Command bit 4 gives a `err_clr` pulse exactly one cycle long and is not held.
- R10: Command bit 7 gives a one-cycle `hunt_start` pulse only in synchronous operation. In asynchronous operation it has no effect.
- R11: Writes with `ctl_sel` = 0 change neither the format state nor any stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| usart_reset | input | 1 | Synchronous hardware reset, active high |
| wr_stb | input | 1 | One-cycle CPU write strobe |
| ctl_sel | input | 1 | 1 = control address, 0 = data address |
| wr_data | input | 8 | Written byte |
| mode_word | output | 8 | Stored mode word |
| sync_mode | output | 1 | Synchronous operation selected |
| sync_chars | output | 8*SYNC_MAX | Stored sync characters |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| send_break | output | 1 | Hold transmit line low |
| err_clr | output | 1 | One-cycle error-flag clear |
| hunt_start | output | 1 | One-cycle sync hunt request |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The bench builds the block with the default `SYNC_MAX` = 2. This makes the worst-case path reachable: mode word, then two sync characters, then command. Runs of three 00h writes are started from each of the four format positions, and the one-sync-character path is covered as well. The bench reads each hidden state only through its effect on the next control write.

// File: rtl/usart_fmt_pkg.sv
// Shared types and fixed bit positions for the control-write sequencer.
// Assumes byte-wide CPU writes; the bit positions are fixed by the driver contract.
package usart_fmt_pkg;
    typedef enum logic [1:0] {
        FMT_MODE = 2'd0,
        FMT_SYNC = 2'd1,
        FMT_CMD  = 2'd2
    } fmt_e;

    localparam int WORD_W      = 8;
    localparam int CB_TXEN     = 0;
    localparam int CB_DTR      = 1;
    localparam int CB_RXEN     = 2;
    localparam int CB_BRK      = 3;
    localparam int CB_ERRCLR   = 4;
    localparam int CB_RTS      = 5;
    localparam int CB_IRESET   = 6;
    localparam int CB_HUNT     = 7;
    localparam int MB_ONE_SYNC = 7;
endpackage

// File: rtl/usart_fmt_fsm.sv
// Format state machine: decides whether a control write is a mode word, a sync
// character or a command word, and issues one write-enable per target register.
// Assumes wr_stb lasts one cycle per CPU write.
module usart_fmt_fsm
    import usart_fmt_pkg::*;
#(
    parameter int SYNC_MAX = 2
) (
    input  logic                clk,
    input  logic                usart_reset,
    input  logic                wr_stb,
    input  logic                ctl_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                one_sync,
    output logic                mode_we,
    output logic [SYNC_MAX-1:0] sync_we,
    output logic                cmd_we
);
    localparam int IDX_W = (SYNC_MAX > 1) ? $clog2(SYNC_MAX) : 1;
    localparam int CNT_W = IDX_W + 1;

    fmt_e             state;
    logic [IDX_W-1:0] sync_idx;
    logic             ctl_wr;
    logic [CNT_W-1:0] sync_need;
    logic             last_sync;

    // Decode the strobe into register enables for the current format.
    always_comb begin
        ctl_wr    = wr_stb && ctl_sel;
        mode_we   = ctl_wr && (state == FMT_MODE);
        cmd_we    = ctl_wr && (state == FMT_CMD);
        sync_need = one_sync ? CNT_W'(1) : CNT_W'(SYNC_MAX);
        last_sync = ({1'b0, sync_idx} == (sync_need - CNT_W'(1)));
    end

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_MAX; gi++) begin : g_sync_we
            // Enable for sync character slot gi.
            assign sync_we[gi] = ctl_wr && (state == FMT_SYNC) && (sync_idx == IDX_W'(gi));
        end
    endgenerate

    // Advance the format state on each control write.
    always_ff @(posedge clk) begin
        if (usart_reset) begin
            state    <= FMT_MODE;
            sync_idx <= '0;
        end else if (ctl_wr) begin
            case (state)
                FMT_MODE: begin
                    sync_idx <= '0;
                    state    <= (wr_data[1:0] == 2'b00) ? FMT_SYNC : FMT_CMD;
                end
                FMT_SYNC: begin
                    if (last_sync) state <= FMT_CMD;
                    else           sync_idx <= sync_idx + IDX_W'(1);
                end
                default: begin
                    if (wr_data[CB_IRESET]) state <= FMT_MODE;
                end
            endcase
        end
    end

    p_ireset_to_mode_r6: assert property (@(posedge clk) disable iff (usart_reset)
        (cmd_we && wr_data[CB_IRESET]) |=> (state == FMT_MODE));
    p_async_to_cmd_r4: assert property (@(posedge clk) disable iff (usart_reset)
        (mode_we && (wr_data[1:0] != 2'b00)) |=> (state == FMT_CMD));
    p_data_hold_r11: assert property (@(posedge clk) disable iff (usart_reset)
        (wr_stb && !ctl_sel) |=> ($stable(state) && $stable(sync_idx)));
endmodule

// File: rtl/usart_mode_store.sv
// Holds the mode word and the sync characters written during the sync phase.
// Assumes at most one enable is active per cycle.
module usart_mode_store
    import usart_fmt_pkg::*;
#(
    parameter int SYNC_MAX = 2
) (
    input  logic                       clk,
    input  logic                       usart_reset,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       mode_we,
    input  logic [SYNC_MAX-1:0]        sync_we,
    output logic [WORD_W-1:0]          mode_word,
    output logic [SYNC_MAX*WORD_W-1:0] sync_chars
);
    // Capture the mode word.
    always_ff @(posedge clk) begin
        if (usart_reset)  mode_word <= '0;
        else if (mode_we) mode_word <= wr_data;
    end

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_MAX; gi++) begin : g_sync
            // Capture sync character slot gi.
            always_ff @(posedge clk) begin
                if (usart_reset)
                    sync_chars[gi*WORD_W +: WORD_W] <= '0;
                else if (sync_we[gi])
                    sync_chars[gi*WORD_W +: WORD_W] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/usart_cmd_reg.sv
// Command register: keeps the level bits and produces the error-clear and
// hunt pulses. Assumes sync_mode is stable whenever a command is written.
module usart_cmd_reg
    import usart_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              usart_reset,
    input  logic              cmd_we,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sync_mode,
    output logic              tx_en,
    output logic              rx_en,
    output logic              send_break,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              err_clr,
    output logic              hunt_start
);
    logic dtr_q, rts_q;

    // Update the level bits; an internal reset clears them.
    always_ff @(posedge clk) begin
        if (usart_reset) begin
            tx_en <= 1'b0; rx_en <= 1'b0; send_break <= 1'b0;
            dtr_q <= 1'b0; rts_q <= 1'b0;
        end else if (cmd_we) begin
            if (wr_data[CB_IRESET]) begin
                tx_en <= 1'b0; rx_en <= 1'b0; send_break <= 1'b0;
                dtr_q <= 1'b0; rts_q <= 1'b0;
            end else begin
                tx_en      <= wr_data[CB_TXEN];
                rx_en      <= wr_data[CB_RXEN];
                send_break <= wr_data[CB_BRK];
                dtr_q      <= wr_data[CB_DTR];
                rts_q      <= wr_data[CB_RTS];
            end
        end
    end

    // One-cycle pulses for the status and receive engines.
    always_ff @(posedge clk) begin
        if (usart_reset) begin
            err_clr    <= 1'b0;
            hunt_start <= 1'b0;
        end else begin
            err_clr    <= cmd_we && wr_data[CB_ERRCLR];
            hunt_start <= cmd_we && wr_data[CB_HUNT] && !wr_data[CB_IRESET] && sync_mode;
        end
    end

    // Drive the modem lines active low.
    always_comb begin
        dtr_n = ~dtr_q;
        rts_n = ~rts_q;
    end

    p_pulse_quiet_r9: assert property (@(posedge clk) disable iff (usart_reset)
        !cmd_we |=> (!err_clr && !hunt_start));
endmodule

// File: rtl/usart_ctl_seq.sv
// Top of the control-write sequencer: format state machine, mode/sync storage
// and command register. Assumes byte writes with a one-cycle strobe.
module usart_ctl_seq
    import usart_fmt_pkg::*;
#(
    parameter int SYNC_MAX = 2
) (
    input  logic                       clk,
    input  logic                       usart_reset,
    input  logic                       wr_stb,
    input  logic                       ctl_sel,
    input  logic [7:0]                 wr_data,
    output logic [7:0]                 mode_word,
    output logic                       sync_mode,
    output logic [SYNC_MAX*8-1:0]      sync_chars,
    output logic                       tx_en,
    output logic                       rx_en,
    output logic                       send_break,
    output logic                       err_clr,
    output logic                       hunt_start,
    output logic                       dtr_n,
    output logic                       rts_n
);
    logic                mode_we, cmd_we;
    logic [SYNC_MAX-1:0] sync_we;

    usart_fmt_fsm #(.SYNC_MAX(SYNC_MAX)) i_fsm (
        .clk(clk), .usart_reset(usart_reset), .wr_stb(wr_stb), .ctl_sel(ctl_sel),
        .wr_data(wr_data), .one_sync(mode_word[MB_ONE_SYNC]),
        .mode_we(mode_we), .sync_we(sync_we), .cmd_we(cmd_we)
    );

    usart_mode_store #(.SYNC_MAX(SYNC_MAX)) i_store (
        .clk(clk), .usart_reset(usart_reset), .wr_data(wr_data),
        .mode_we(mode_we), .sync_we(sync_we),
        .mode_word(mode_word), .sync_chars(sync_chars)
    );

    // Synchronous operation is chosen by a zero clock-factor field.
    always_comb sync_mode = (mode_word[1:0] == 2'b00);

    usart_cmd_reg i_cmd (
        .clk(clk), .usart_reset(usart_reset), .cmd_we(cmd_we), .wr_data(wr_data),
        .sync_mode(sync_mode), .tx_en(tx_en), .rx_en(rx_en), .send_break(send_break),
        .dtr_n(dtr_n), .rts_n(rts_n), .err_clr(err_clr), .hunt_start(hunt_start)
    );

    p_hunt_sync_only_r10: assert property (@(posedge clk) disable iff (usart_reset)
        hunt_start |-> sync_mode);
endmodule

// File: tb/test_usart_ctl_seq.sv
module test_usart_ctl_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC_MAX   = 2;

    logic clk = 1'b0;
    logic usart_reset = 1'b1;
    logic wr_stb = 1'b0, ctl_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] mode_word;
    logic sync_mode, tx_en, rx_en, send_break, err_clr, hunt_start, dtr_n, rts_n;
    logic [SYNC_MAX*8-1:0] sync_chars;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usart_ctl_seq #(.SYNC_MAX(SYNC_MAX)) i_usart_ctl_seq (
        .clk(clk), .usart_reset(usart_reset), .wr_stb(wr_stb), .ctl_sel(ctl_sel),
        .wr_data(wr_data), .mode_word(mode_word), .sync_mode(sync_mode),
        .sync_chars(sync_chars), .tx_en(tx_en), .rx_en(rx_en), .send_break(send_break),
        .err_clr(err_clr), .hunt_start(hunt_start), .dtr_n(dtr_n), .rts_n(rts_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Outputs packed as {tx,rx,brk,dtr_n,rts_n}.
    function automatic logic [15:0] lv();
        return {11'd0, tx_en, rx_en, send_break, dtr_n, rts_n};
    endfunction

    task automatic wr(input logic c, input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; ctl_sel = c; wr_data = d;
        @(negedge clk); wr_stb = 1'b0; ctl_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); usart_reset = 1'b1;
        @(negedge clk); @(negedge clk); usart_reset = 1'b0;
    endtask

    task automatic t_reset();
        wr(1, 8'h4E); wr(1, 8'h2F);
        do_reset();
        chk("R1 levels", lv(), 16'h0003);
        wr(1, 8'h4D);
        chk("R1 first write is mode", 16'(mode_word), 16'h004D);
    endtask

    task automatic t_async();
        do_reset(); wr(1, 8'h4E);
        chk("R2 16x async", 16'(sync_mode), 16'h0);
        wr(1, 8'h05);
        chk("R4 command after mode", lv(), 16'h001B);
        do_reset(); wr(1, 8'h4F); chk("R2 64x async", 16'(sync_mode), 16'h0);
        do_reset(); wr(1, 8'h41); chk("R2 1x async", 16'(sync_mode), 16'h0);
    endtask

    task automatic t_sync_two();
        do_reset(); wr(1, 8'h0C);
        chk("R2 sync select", 16'(sync_mode), 16'h1);
        wr(1, 8'h16); wr(1, 8'h05);
        chk("R3 second sync taken", 16'(sync_chars), 16'h0516);
        chk("R3 not yet command", lv(), 16'h0003);
        wr(1, 8'h01);
        chk("R3 command after two", lv(), 16'h0013);
    endtask

    task automatic t_sync_one();
        do_reset(); wr(1, 8'h8C); wr(1, 8'h7E); wr(1, 8'h04);
        chk("R3 one sync then command", lv(), 16'h000B);
        chk("R3 slot1 untouched", 16'(sync_chars[15:8]), 16'h0000);
    endtask

    task automatic t_cmd_bits();
        do_reset(); wr(1, 8'h4E);
        wr(1, 8'h0A); chk("R7 R8 brk dtr", lv(), 16'h0005);
        wr(1, 8'h20); chk("R8 rts only", lv(), 16'h0002);
        wr(1, 8'h27); chk("R7 R8 all", lv(), 16'h0018);
    endtask

    task automatic t_err_pulse();
        do_reset(); wr(1, 8'h4E); wr(1, 8'h15);
        chk("R9 pulse high", 16'(err_clr), 16'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", 16'(err_clr), 16'h0);
        chk("R9 not held", lv(), 16'h001B);
    endtask

    task automatic t_hunt();
        do_reset(); wr(1, 8'h4E); wr(1, 8'h84);
        chk("R10 async no hunt", 16'(hunt_start), 16'h0);
        chk("R10 async rx still set", lv(), 16'h000B);
        do_reset(); wr(1, 8'h8C); wr(1, 8'h33); wr(1, 8'h84);
        chk("R10 sync hunt", 16'(hunt_start), 16'h1);
        @(negedge clk);
        chk("R10 hunt one cycle", 16'(hunt_start), 16'h0);
    endtask

    task automatic t_ireset();
        do_reset(); wr(1, 8'h4E); wr(1, 8'h27); wr(1, 8'h40);
        chk("R6 cleared", lv(), 16'h0003);
        wr(1, 8'h7B);
        chk("R6 next is mode", 16'(mode_word), 16'h007B);
        wr(1, 8'h01); chk("R6 then command", lv(), 16'h0013);
    endtask

    task automatic t_three_zero();
        // From each format position: mode, sync slot 0, sync slot 1, command.
        for (int p = 0; p < 4; p++) begin
            do_reset();
            if (p >= 1) wr(1, 8'h0C);
            if (p >= 2) wr(1, 8'h11);
            if (p >= 3) wr(1, 8'h22);
            wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h00);
            wr(1, 8'h05);
            chk($sformatf("R5 three zeros from pos %0d", p), lv(), 16'h001B);
        end
        do_reset(); wr(1, 8'h4E); wr(1, 8'h27);
        wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h01);
        chk("R5 from async command", lv(), 16'h0013);
    endtask

    task automatic t_data_ignored();
        do_reset(); wr(0, 8'h4E); wr(1, 8'h4D);
        chk("R11 data not mode", 16'(mode_word), 16'h004D);
        wr(0, 8'h40); wr(0, 8'h27);
        chk("R11 data not command", lv(), 16'h0003);
        wr(1, 8'h01);
        chk("R11 state held", lv(), 16'h0013);
        chk("R11 mode held", 16'(mode_word), 16'h004D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        usart_reset = 1'b0;
        chk("R1 reset levels", lv(), 16'h0003);
        t_reset(); t_async(); t_sync_two(); t_sync_one(); t_cmd_bits();
        t_err_pulse(); t_hunt(); t_ireset(); t_three_zero(); t_data_ignored();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule